// File: doc/BRIEF.md
# Size-Reconfigurable FFT Tail Stages

This block forms the final three pipeline stages of an eight-lane pipelined FFT whose total length is 128, 256 or 512 points. Each clock it accepts eight complex samples, each part 12-bit two's complement, with a valid flag, a start-of-frame flag and a two-bit size code. It computes the last small DFT of length N/64. For 128 that is four independent 2-point DFTs. For 256 it is two independent 4-point DFTs. For 512 it is one 8-point DFT across all lanes. One set of three radix-2 butterfly layers does all three jobs. Multiplexers bypass the layers that the current size does not need, and they enable the trivial -j rotations and the W8 constant rotation between layers.

Results leave in bit-reversed position order within each small DFT. Reordering is left to a downstream block, which reads the size tag `out_mode` that travels with the data. Each active butterfly halves its result, so a P-point DFT comes out divided by P.

A three-state size controller holds the current size. Its states are MODE_P2 (code 00), MODE_P4 (code 01) and MODE_P8 (codes 11 and 10). Reset enters MODE_P2. There is one transition, "frame restart": on a beat with `in_valid` and `in_sof` both high, the controller moves from any state to the state that `in_mode` decodes to, and that same beat already uses the new size. On every other beat the controller holds its state.

Top module: `fft_tail_stages`

## Requirements
- R1: With size MODE_P2, lanes (2m, 2m+1) form a 2-point DFT for m = 0..3. Output lane 2m carries the halved sum and output lane 2m+1 carries the halved difference (first minus second), each computed separately on the real and imaginary parts.
- R2: With size MODE_P4, lanes 0..3 and lanes 4..7 each form a 4-point DFT divided by 4. Output lanes 4g+0..4g+3 hold the bins X0, X2, X1, X3.
- R3: With size MODE_P8 (code 11), the eight lanes form one 8-point DFT divided by 8. Output lane p holds bin X[bitreverse3(p)].
- R4: Size code 10 behaves exactly like code 11, and the output size tag reads 11 for it.
- R5: Every butterfly result is (a±b+1)>>>1, which rounds halves upward, and is then saturated to [-2048, 2047].
- R6: The W8 rotation multiplies by 1448/2048, rounds by adding 1024 before an arithmetic shift right by 11, and saturates to 12 bits.
- R7: `in_mode` is taken only on a beat with both `in_valid` and `in_sof` high. At any other time it has no effect. After reset the size is MODE_P2.
- R8: Latency is exactly three cycles in every size. `out_valid`, `out_sof` and `out_mode` equal the input valid, the input start-of-frame and the effective size code (00, 01 or 11) from three cycles earlier.
- R9: During reset and in the first cycle after it, `out_valid` and `out_sof` are low and all output data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_sof | input | 1 | First beat of a frame; permits a size change |
| in_mode | input | 2 | Size code: 00 = 128, 01 = 256, 11 or 10 = 512 |
| in_re | input | 96 | Real parts; lane l occupies bits [12l+11:12l] |
| in_im | input | 96 | Imaginary parts, same lane layout |
| out_valid | output | 1 | Output beat valid |
| out_sof | output | 1 | Start-of-frame flag, delayed |
| out_mode | output | 2 | Effective size code of this output beat |
| out_re | output | 96 | Result real parts, bit-reversed bin order per group |
| out_im | output | 96 | Result imaginary parts |

## Verification
The checker's properties assume that no beat carrying both valid and start-of-frame is presented while reset is asserted. They also assume that reset is held for at least one clock edge, so that the three-cycle alignment counters start from a known point. The stimulus drives all inputs on the falling edge and holds `in_valid` low for the whole reset period. Deliberate size-code changes without a start-of-frame flag are confined to valid beats, so that the controller's hold behaviour is exercised at the ports rather than assumed.

// File: rtl/fft_tail_pkg.sv
package fft_tail_pkg;

    localparam int LANES = 8;

    typedef enum logic [1:0] {
        MODE_P2 = 2'b00,
        MODE_P4 = 2'b01,
        MODE_P8 = 2'b11
    } tail_mode_e;

    typedef enum logic [1:0] {
        ROT_NONE,
        ROT_NEG_J,
        ROT_W8,
        ROT_W8_3
    } rot_kind_e;

    // A butterfly layer of a given span is used only for sizes large enough.
    function automatic logic stage_active(int span, tail_mode_e m);
        if (span >= 4)      return m == MODE_P8;
        else if (span == 2) return m != MODE_P2;
        else                return 1'b1;
    endfunction

    // Boundary 0 sits after the span-4 layer, boundary 1 after the span-2 layer.
    function automatic rot_kind_e rot_select(int boundary, int lane, tail_mode_e m);
        rot_kind_e k;
        k = ROT_NONE;
        if (boundary == 0) begin
            if (m == MODE_P8) begin
                if (lane == 5)      k = ROT_W8;
                else if (lane == 6) k = ROT_NEG_J;
                else if (lane == 7) k = ROT_W8_3;
            end
        end else begin
            if (m != MODE_P2 && (lane % 4) == 3) k = ROT_NEG_J;
        end
        return k;
    endfunction

    function automatic int clamp(int v, int dw);
        int lim;
        lim = 1 << (dw - 1);
        if (v > lim - 1)  return lim - 1;
        else if (v < -lim) return -lim;
        else              return v;
    endfunction

    function automatic int half_round(int v);
        return (v + 1) >>> 1;
    endfunction

    function automatic int w8_scale(int v, int coef, int dw);
        return (v * coef + (1 << (dw - 2))) >>> (dw - 1);
    endfunction

endpackage

// File: rtl/tail_mode_fsm.sv
module tail_mode_fsm
    import fft_tail_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic [1:0] mode_code,
    output tail_mode_e eff_mode
);

    tail_mode_e state_q;
    tail_mode_e state_d;

    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            unique case (mode_code)
                2'b00:        state_d = MODE_P2;
                2'b01:        state_d = MODE_P4;
                2'b10, 2'b11: state_d = MODE_P8;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_P2;
        else        state_q <= state_d;
    end

    // The frame-start beat itself already runs in the newly selected size.
    always_comb begin
        eff_mode = state_d;
    end

endmodule

// File: rtl/tail_bfly_stage.sv
module tail_bfly_stage
    import fft_tail_pkg::*;
#(
    parameter int DW   = 12,
    parameter int SPAN = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  tail_mode_e           in_mode,
    input  logic signed [DW-1:0] in_re [LANES],
    input  logic signed [DW-1:0] in_im [LANES],
    output logic                 out_valid,
    output logic                 out_sof,
    output tail_mode_e           out_mode,
    output logic signed [DW-1:0] out_re [LANES],
    output logic signed [DW-1:0] out_im [LANES]
);

    logic                 act;
    logic signed [DW-1:0] nx_re [LANES];
    logic signed [DW-1:0] nx_im [LANES];

    assign act = stage_active(SPAN, in_mode);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam bit LOWER   = ((g / SPAN) % 2) == 1;
        localparam int PARTNER = LOWER ? g - SPAN : g + SPAN;
        always_comb begin
            if (!act) begin
                nx_re[g] = in_re[g];
                nx_im[g] = in_im[g];
            end else if (!LOWER) begin
                nx_re[g] = DW'(clamp(half_round(int'(in_re[g]) + int'(in_re[PARTNER])), DW));
                nx_im[g] = DW'(clamp(half_round(int'(in_im[g]) + int'(in_im[PARTNER])), DW));
            end else begin
                nx_re[g] = DW'(clamp(half_round(int'(in_re[PARTNER]) - int'(in_re[g])), DW));
                nx_im[g] = DW'(clamp(half_round(int'(in_im[PARTNER]) - int'(in_im[g])), DW));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_mode  <= MODE_P2;
            for (int i = 0; i < LANES; i++) begin
                out_re[i] <= '0;
                out_im[i] <= '0;
            end
        end else begin
            out_valid <= in_valid;
            out_sof   <= in_sof;
            out_mode  <= in_mode;
            for (int i = 0; i < LANES; i++) begin
                out_re[i] <= nx_re[i];
                out_im[i] <= nx_im[i];
            end
        end
    end

endmodule

// File: rtl/tail_rotator.sv
module tail_rotator
    import fft_tail_pkg::*;
#(
    parameter int DW       = 12,
    parameter int BOUNDARY = 0
) (
    input  tail_mode_e           in_mode,
    input  logic signed [DW-1:0] in_re  [LANES],
    input  logic signed [DW-1:0] in_im  [LANES],
    output logic signed [DW-1:0] out_re [LANES],
    output logic signed [DW-1:0] out_im [LANES]
);

    localparam int W8_COEF = $rtoi(real'(1 << (DW - 1)) * 0.7071067811865476 + 0.5);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rot_kind_e kind;
        int        a;
        int        b;
        assign kind = rot_select(BOUNDARY, g, in_mode);
        assign a    = int'(in_re[g]);
        assign b    = int'(in_im[g]);
        always_comb begin
            unique case (kind)
                ROT_NONE: begin
                    out_re[g] = in_re[g];
                    out_im[g] = in_im[g];
                end
                ROT_NEG_J: begin
                    out_re[g] = in_im[g];
                    out_im[g] = DW'(clamp(-a, DW));
                end
                ROT_W8: begin
                    out_re[g] = DW'(clamp(w8_scale(a + b, W8_COEF, DW), DW));
                    out_im[g] = DW'(clamp(w8_scale(b - a, W8_COEF, DW), DW));
                end
                ROT_W8_3: begin
                    out_re[g] = DW'(clamp(w8_scale(b - a, W8_COEF, DW), DW));
                    out_im[g] = DW'(clamp(w8_scale(-a - b, W8_COEF, DW), DW));
                end
            endcase
        end
    end

endmodule

// File: rtl/fft_tail_stages.sv
module fft_tail_stages
    import fft_tail_pkg::*;
#(
    parameter int DW = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sof,
    input  logic [1:0]            in_mode,
    input  logic [LANES*DW-1:0]   in_re,
    input  logic [LANES*DW-1:0]   in_im,
    output logic                  out_valid,
    output logic                  out_sof,
    output logic [1:0]            out_mode,
    output logic [LANES*DW-1:0]   out_re,
    output logic [LANES*DW-1:0]   out_im
);

    tail_mode_e           cur_mode;
    logic signed [DW-1:0] a_re [LANES], a_im [LANES];
    logic signed [DW-1:0] s1_re [LANES], s1_im [LANES];
    logic signed [DW-1:0] r1_re [LANES], r1_im [LANES];
    logic signed [DW-1:0] s2_re [LANES], s2_im [LANES];
    logic signed [DW-1:0] r2_re [LANES], r2_im [LANES];
    logic signed [DW-1:0] s3_re [LANES], s3_im [LANES];
    logic       s1_valid, s1_sof, s2_valid, s2_sof;
    tail_mode_e s1_mode, s2_mode, s3_mode;

    for (genvar g = 0; g < LANES; g++) begin : g_io
        assign a_re[g]            = in_re[g*DW +: DW];
        assign a_im[g]            = in_im[g*DW +: DW];
        assign out_re[g*DW +: DW] = s3_re[g];
        assign out_im[g*DW +: DW] = s3_im[g];
    end

    tail_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(in_valid && in_sof),
        .mode_code  (in_mode),
        .eff_mode   (cur_mode)
    );

    tail_bfly_stage #(.DW(DW), .SPAN(4)) u_stage_a (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_mode(cur_mode),
        .in_re(a_re), .in_im(a_im),
        .out_valid(s1_valid), .out_sof(s1_sof), .out_mode(s1_mode),
        .out_re(s1_re), .out_im(s1_im)
    );

    tail_rotator #(.DW(DW), .BOUNDARY(0)) u_rot_a (
        .in_mode(s1_mode), .in_re(s1_re), .in_im(s1_im),
        .out_re(r1_re), .out_im(r1_im)
    );

    tail_bfly_stage #(.DW(DW), .SPAN(2)) u_stage_b (
        .clk(clk), .rst_n(rst_n),
        .in_valid(s1_valid), .in_sof(s1_sof), .in_mode(s1_mode),
        .in_re(r1_re), .in_im(r1_im),
        .out_valid(s2_valid), .out_sof(s2_sof), .out_mode(s2_mode),
        .out_re(s2_re), .out_im(s2_im)
    );

    tail_rotator #(.DW(DW), .BOUNDARY(1)) u_rot_b (
        .in_mode(s2_mode), .in_re(s2_re), .in_im(s2_im),
        .out_re(r2_re), .out_im(r2_im)
    );

    tail_bfly_stage #(.DW(DW), .SPAN(1)) u_stage_c (
        .clk(clk), .rst_n(rst_n),
        .in_valid(s2_valid), .in_sof(s2_sof), .in_mode(s2_mode),
        .in_re(r2_re), .in_im(r2_im),
        .out_valid(out_valid), .out_sof(out_sof), .out_mode(s3_mode),
        .out_re(s3_re), .out_im(s3_im)
    );

    assign out_mode = s3_mode;

endmodule

// File: rtl/fft_tail_checker.sv
module fft_tail_checker
    import fft_tail_pkg::*;
#(
    parameter int DW = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_sof,
    input logic [LANES*DW-1:0] in_re,
    input logic [LANES*DW-1:0] in_im,
    input logic                out_valid,
    input logic                out_sof,
    input logic [LANES*DW-1:0] out_re,
    input logic [LANES*DW-1:0] out_im,
    input tail_mode_e          cur_mode
);

    logic [1:0] warm_cnt;
    logic       warm;

    always_ff @(posedge clk) begin
        if (!rst_n)              warm_cnt <= 2'd0;
        else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
    end
    assign warm = warm_cnt == 2'd3;

    assert_latency_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> out_valid == $past(in_valid, 3));

    assert_latency_sof_R8: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> out_sof == $past(in_sof, 3));

    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cnt != 2'd0 && !(in_valid && in_sof)) |-> cur_mode == $past(cur_mode));

    assert_zero_maps_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(in_valid && in_re == '0 && in_im == '0, 3)) |-> (out_re == '0 && out_im == '0));

    assert_reset_quiet_R9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_sof && out_re == '0));

endmodule

bind fft_tail_stages fft_tail_checker #(.DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_re    (in_re),
    .in_im    (in_im),
    .out_valid(out_valid),
    .out_sof  (out_sof),
    .out_re   (out_re),
    .out_im   (out_im),
    .cur_mode (cur_mode)
);

// File: tb/fft_tail_stages_tb_top.sv
`timescale 1ns/1ps
module fft_tail_stages_tb_top;

    localparam int DW = 12;
    localparam int NL = 8;
    localparam int NV = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_sof = 1'b0;
    logic [1:0]        in_mode = 2'b00;
    logic [NL*DW-1:0]  in_re = '0;
    logic [NL*DW-1:0]  in_im = '0;
    logic              out_valid;
    logic              out_sof;
    logic [1:0]        out_mode;
    logic [NL*DW-1:0]  out_re;
    logic [NL*DW-1:0]  out_im;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fft_tail_stages #(.DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_mode(in_mode),
        .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_sof(out_sof), .out_mode(out_mode),
        .out_re(out_re), .out_im(out_im)
    );

    // Size code, start-of-frame, expected output size tag
    localparam int VMODE [NV] = '{0, 1, 3, 3, 3, 2, 0, 0, 3, 1};
    localparam int VSOF  [NV] = '{1, 1, 1, 1, 1, 1, 0, 1, 0, 1};
    localparam int VTAG  [NV] = '{0, 1, 3, 3, 3, 3, 3, 0, 0, 1};

    localparam int VIN_RE [NV][NL] = '{
        '{100, 20, -50, 30, 7, 7, 2047, -2048},
        '{400, 200, 0, 0, 0, 0, 0, 0},
        '{800, 0, 0, 0, 0, 0, 0, 0},
        '{0, 1024, 0, 0, 0, 0, 0, 0},
        '{0, 2047, 0, 0, 0, -2048, 0, 0},
        '{800, 0, 0, 0, 0, 0, 0, 0},
        '{800, 0, 0, 0, 0, 0, 0, 0},
        '{800, 0, 0, 0, 0, 0, 0, 0},
        '{800, 0, 0, 0, 0, 0, 0, 0},
        '{5, 0, 0, 0, -5, 0, 0, 0}
    };
    localparam int VIN_IM [NV][NL] = '{
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{0, 0, 0, 0, 0, 0, 0, 8},
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{0, 2047, 0, 0, 0, -2048, 0, 0},
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{0, 0, 0, 0, 0, 0, 0, 0}
    };
    localparam int VEX_RE [NV][NL] = '{
        '{60, 40, -10, -40, 7, 0, 0, 2047},
        '{150, 50, 100, 100, 0, 0, -2, 2},
        '{100, 100, 100, 100, 100, 100, 100, 100},
        '{128, -128, 0, 0, 91, -90, -90, 91},
        '{0, 0, 0, 0, 512, -512, 0, 0},
        '{100, 100, 100, 100, 100, 100, 100, 100},
        '{100, 100, 100, 100, 100, 100, 100, 100},
        '{400, 400, 0, 0, 0, 0, 0, 0},
        '{400, 400, 0, 0, 0, 0, 0, 0},
        '{2, 2, 2, 2, -1, -1, -1, -1}
    };
    localparam int VEX_IM [NV][NL] = '{
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{0, 0, -50, 50, 2, -2, 0, 0},
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{0, 0, -128, 128, -90, 91, -90, 91},
        '{0, 0, 0, 0, 0, 0, -512, 512},
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{0, 0, 0, 0, 0, 0, 0, 0}
    };

    // Requirement covered by each table row
    function automatic string vec_req(int k);
        case (k)
            0: return "R1 R5 saturation";
            1: return "R2";
            2: return "R3 impulse";
            3: return "R3 R6 rounding";
            4: return "R6 saturation";
            5: return "R4 code 10";
            6: return "R7 change without sof";
            7: return "R7 change with sof";
            8: return "R7 change without sof";
            default: return "R5 rounding";
        endcase
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lane_re(int l);
        return int'($signed(out_re[l*DW +: DW]));
    endfunction

    function automatic int lane_im(int l);
        return int'($signed(out_im[l*DW +: DW]));
    endfunction

    task automatic drive_vec(int k);
        in_valid = 1'b1;
        in_sof   = VSOF[k][0];
        in_mode  = VMODE[k][1:0];
        for (int l = 0; l < NL; l++) begin
            in_re[l*DW +: DW] = DW'(VIN_RE[k][l]);
            in_im[l*DW +: DW] = DW'(VIN_IM[k][l]);
        end
    endtask

    task automatic check_vec(int k);
        string r;
        r = vec_req(k);
        chk(r, "out_valid R8", int'(out_valid), 1);
        chk(r, "out_sof R8", int'(out_sof), VSOF[k]);
        chk(r, "out_mode R8", int'(out_mode), VTAG[k]);
        for (int l = 0; l < NL; l++) begin
            chk(r, $sformatf("re lane %0d", l), lane_re(l), VEX_RE[k][l]);
            chk(r, $sformatf("im lane %0d", l), lane_im(l), VEX_IM[k][l]);
        end
    endtask

    task automatic idle_inputs();
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_mode  = 2'b00;
        in_re    = '0;
        in_im    = '0;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9", "out_valid in reset", int'(out_valid), 0);
        chk("R9", "out_sof in reset", int'(out_sof), 0);
        chk("R9", "out_re in reset", int'(out_re != '0), 0);
        chk("R9", "out_mode in reset", int'(out_mode), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "out_valid after reset", int'(out_valid), 0);

        // Streamed table: result of row k appears three cycles after it is driven
        for (int k = 0; k < NV + 3; k++) begin
            if (k >= 3) check_vec(k - 3);
            if (k < NV) drive_vec(k);
            else        idle_inputs();
            @(negedge clk);
        end

        // R8: single pulse latency
        idle_inputs();
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = 1'b1;
        in_mode  = 2'b01;
        @(negedge clk);
        idle_inputs();
        chk("R8", "valid after 1 cycle", int'(out_valid), 0);
        @(negedge clk);
        chk("R8", "valid after 2 cycles", int'(out_valid), 0);
        @(negedge clk);
        chk("R8", "valid after 3 cycles", int'(out_valid), 1);
        chk("R8", "sof after 3 cycles", int'(out_sof), 1);
        chk("R8", "mode tag after 3 cycles", int'(out_mode), 1);
        @(negedge clk);
        chk("R8", "valid after 4 cycles", int'(out_valid), 0);

        // R7: reset returns size to 128; code 11 without sof is ignored
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b1;
        in_sof   = 1'b0;
        in_mode  = 2'b11;
        in_re[0 +: DW] = DW'(800);
        @(negedge clk);
        idle_inputs();
        repeat (2) @(negedge clk);
        chk("R7", "size after reset: out_mode", int'(out_mode), 0);
        chk("R7", "size after reset: lane0", lane_re(0), 400);
        chk("R7", "size after reset: lane1", lane_re(1), 400);
        chk("R7", "size after reset: lane2", lane_re(2), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule